// File: doc/BRIEF.md
# Reloadable Core Clock Divider

This block takes one core clock and produces one or more divided clock outputs. Software programs it through a small register port that has a write strobe, a byte offset, write data and combinational read data. Two words are mapped. The control word holds the output enables, one reload-request bit for each output and one shared reload trigger. The ratio word holds a divide field for each output.

A ratio written into the ratio word does not change the output straight away. It is staged, and it becomes active only after the output's reload-request bit and the shared trigger are both set. The divider adopts the staged value at the start of its next output period, so every period it produces is a complete period at either the old ratio or the new one. Four divide ratios are supported: 4, 5, 6 and 8. A reload that finds any other value in the field leaves the running ratio as it is.

Top module: `corediv_top`

## Requirements
- R1: After reset, the control word reads 0, the ratio word reads 0x0000_0800 (divide field of output index 1 equal to 8), and every divided output is low.
- R2: The control word sits at byte offset 0x0 and the ratio word at byte offset 0x8. Both read back the last value written to them. Any other offset reads 0, and a write to it changes neither word.
- R3: The enable for the output with index n is control bit 24+n, so bit 25 for the default output index 1. While that bit is clear, the output is low one cycle later and stays low.
- R4: The divide field of output index 1 is ratio-word bits [13:8]. A new value written there leaves the output's period unchanged until control bit 1 (reload request) and control bit 8 (trigger) have both been set.
- R5: Setting the trigger (bit 8) while the output's reload-request bit is clear does not change that output's ratio.
- R6: An enabled output repeats with a period equal to the active ratio in input cycles. Each period starts high, stays high for floor(ratio/2) cycles and is low for the remaining cycles. This holds for ratios 4, 5, 6 and 8.
- R7: If a reload finds a divide field other than 4, 5, 6 or 8, the active ratio stays unchanged.
- R8: A new ratio is adopted only at the start of a period, immediately after a low phase ends. Every observed period is therefore a complete period at either the old ratio or the new one.
- R9: Clearing control bits [8:0] after a reload leaves the active ratio unchanged.
- R10: The active ratio after reset is 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (4) | Byte offset of the accessed word |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data for `addr` (combinational) |
| clk_div_o | output | NUM_OUT (1) | Divided clock outputs, bit k for output index FIRST_IDX+k |

## Verification
The output is measured over whole periods, counting the length of the high run and of the low run, for each of the four legal ratios. This separates the even ratios from the odd ones and shows whether the high time is rounded down. Reload sequences differ in one condition at a time: request bit only, trigger only, both bits with a legal field, and both bits with an illegal field. A write that wrongly takes effect can therefore be told apart from a reload that was wrongly blocked. The periods observed while a new ratio is being adopted are each checked to be a complete old or new period. A final disabled stretch confirms that the output stays low.

// File: rtl/corediv_pkg.sv
package corediv_pkg;
   localparam int CTRL_OFS     = 0;
   localparam int RATIO_OFS    = 8;
   localparam int TRIG_BIT     = 8;
   localparam int EN_BASE      = 24;
   localparam int FIELD_STRIDE = 8;
   localparam int RST_RATIO    = 8;

   function automatic logic ratio_legal(input logic [7:0] r);
      return (r == 8'd4) || (r == 8'd5) || (r == 8'd6) || (r == 8'd8);
   endfunction
endpackage

// File: rtl/corediv_regs.sv
module corediv_regs
   import corediv_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 32,
   parameter int RATIO_W   = 6,
   parameter int FIRST_IDX = 1,
   parameter int NUM_OUT   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] ctrl_q,
   output logic [DATA_W-1:0] ratio_q
);
   localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_OFS);
   localparam logic [ADDR_W-1:0] RATIO_A = ADDR_W'(RATIO_OFS);

   function automatic logic [DATA_W-1:0] ratio_reset();
      logic [DATA_W-1:0] v = '0;
      for (int k = 0; k < NUM_OUT; k++)
         v[FIELD_STRIDE*(FIRST_IDX+k) +: RATIO_W] = RATIO_W'(RST_RATIO);
      return v;
   endfunction

   localparam logic [DATA_W-1:0] RATIO_RST = ratio_reset();

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         ratio_q <= RATIO_RST;
      end else if (wr_en) begin
         if (addr == CTRL_A)  ctrl_q  <= wdata;
         if (addr == RATIO_A) ratio_q <= wdata;
      end
   end

   always_comb begin
      if (addr == CTRL_A)       rdata = ctrl_q;
      else if (addr == RATIO_A) rdata = ratio_q;
      else                      rdata = '0;
   end
endmodule

// File: rtl/corediv_chan.sv
module corediv_chan
   import corediv_pkg::*;
#(
   parameter int RATIO_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               reload_req,
   input  logic               trig,
   input  logic [RATIO_W-1:0] field,
   output logic               div_o,
   output logic [RATIO_W-1:0] act_o,
   output logic               pend_o
);
   localparam logic [RATIO_W-1:0] RST_R = RATIO_W'(RST_RATIO);

   logic [RATIO_W-1:0] act_q, nxt_q, cnt_q;
   logic [RATIO_W-1:0] act_d, nxt_d, cnt_d;
   logic               pend_q, pend_d, out_q, out_d;
   logic               reload_ok, wrap, boundary;

   always_comb begin
      reload_ok = reload_req && trig && ratio_legal(8'(field));
      wrap      = (cnt_q == act_q - 1'b1);
      boundary  = !en || wrap;

      act_d  = act_q;
      nxt_d  = nxt_q;
      pend_d = pend_q;
      if (boundary && pend_q) begin
         act_d  = nxt_q;
         pend_d = 1'b0;
      end
      if (reload_ok) begin
         nxt_d  = field;
         pend_d = 1'b1;
      end

      if (!en)       cnt_d = act_d - 1'b1;
      else if (wrap) cnt_d = '0;
      else           cnt_d = cnt_q + 1'b1;

      out_d = en && (cnt_d < (act_d >> 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= RST_R;
         nxt_q  <= RST_R;
         cnt_q  <= RST_R - 1'b1;
         pend_q <= 1'b0;
         out_q  <= 1'b0;
      end else begin
         act_q  <= act_d;
         nxt_q  <= nxt_d;
         cnt_q  <= cnt_d;
         pend_q <= pend_d;
         out_q  <= out_d;
      end
   end

   assign div_o  = out_q;
   assign act_o  = act_q;
   assign pend_o = pend_q;
endmodule

// File: rtl/corediv_top.sv
module corediv_top
   import corediv_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int DATA_W    = 32,
   parameter int RATIO_W   = 6,
   parameter int FIRST_IDX = 1,
   parameter int NUM_OUT   = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rdata,
   output logic [NUM_OUT-1:0] clk_div_o
);
   localparam int LAST_IDX = FIRST_IDX + NUM_OUT - 1;

   if (RATIO_W < 4)                                   $error("RATIO_W too small for ratio 8");
   if (DATA_W < 32)                                   $error("DATA_W must hold enable bits");
   if (NUM_OUT < 1)                                   $error("NUM_OUT must be at least 1");
   if (LAST_IDX > 7)                                  $error("reload requests live in bits 7:0");
   if (EN_BASE + LAST_IDX > DATA_W - 1)               $error("enable bit out of range");
   if (FIELD_STRIDE*LAST_IDX + RATIO_W > DATA_W)      $error("ratio field out of range");
   if (RATIO_W > FIELD_STRIDE)                        $error("ratio fields overlap");
   if ((1 << ADDR_W) <= RATIO_OFS)                    $error("ADDR_W cannot reach ratio word");

   logic [DATA_W-1:0]               ctrl_q, ratio_q;
   logic [NUM_OUT-1:0][RATIO_W-1:0] act_all;
   logic [NUM_OUT-1:0]              pend_all;

   corediv_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RATIO_W(RATIO_W),
      .FIRST_IDX(FIRST_IDX), .NUM_OUT(NUM_OUT)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .ctrl_q(ctrl_q), .ratio_q(ratio_q)
   );

   for (genvar k = 0; k < NUM_OUT; k++) begin : g_chan
      localparam int IDX = FIRST_IDX + k;
      corediv_chan #(.RATIO_W(RATIO_W)) chan_i (
         .clk(clk),
         .rst_n(rst_n),
         .en(ctrl_q[EN_BASE+IDX]),
         .reload_req(ctrl_q[IDX]),
         .trig(ctrl_q[TRIG_BIT]),
         .field(ratio_q[FIELD_STRIDE*IDX +: RATIO_W]),
         .div_o(clk_div_o[k]),
         .act_o(act_all[k]),
         .pend_o(pend_all[k])
      );
   end
endmodule

// File: rtl/corediv_chk.sv
module corediv_chk
   import corediv_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int RATIO_W   = 6,
   parameter int FIRST_IDX = 1,
   parameter int NUM_OUT   = 1
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic [DATA_W-1:0]                 ctrl_q,
   input logic [NUM_OUT-1:0][RATIO_W-1:0]   act_all,
   input logic [NUM_OUT-1:0]                pend_all,
   input logic [NUM_OUT-1:0]                clk_div_o
);
   for (genvar k = 0; k < NUM_OUT; k++) begin : g_chk
      localparam int IDX = FIRST_IDX + k;

      // R7
      legal_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ratio_legal(8'(act_all[k])));

      // R8
      switch_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (act_all[k] != $past(act_all[k])) |-> (!$past(clk_div_o[k]) || !$past(ctrl_q[EN_BASE+IDX])));

      // R3
      disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !ctrl_q[EN_BASE+IDX] |=> !clk_div_o[k]);

      // R4
      no_reload_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!ctrl_q[TRIG_BIT] && !pend_all[k]) |=> $stable(act_all[k]));
   end
endmodule

bind corediv_top corediv_chk #(
   .DATA_W(DATA_W), .RATIO_W(RATIO_W), .FIRST_IDX(FIRST_IDX), .NUM_OUT(NUM_OUT)
) chk_i (
   .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .act_all(act_all),
   .pend_all(pend_all), .clk_div_o(clk_div_o)
);

// File: tb/corediv_top_tb_top.sv
`timescale 1ns/1ps
module corediv_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [0:0]  clk_div_o;

   int checks = 0;
   int errors = 0;

   localparam logic [31:0] EN1   = 32'h0200_0000;
   localparam logic [31:0] REQ1  = 32'h0000_0002;
   localparam logic [31:0] TRIG  = 32'h0000_0100;

   always #4 clk = ~clk;

   corediv_top dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .clk_div_o(clk_div_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      addr = a;
      #1;
      checks++;
      if (rdata !== exp) begin
         errors++;
         $display("FAIL %s read 0x%0h actual=0x%08h expected=0x%08h", req, a, rdata, exp);
      end
   endtask

   // measure one full period: high run then low run
   task automatic measure(output int hi, output int lo);
      int guard = 0;
      hi = 0; lo = 0;
      @(negedge clk);
      while (clk_div_o[0] !== 1'b0 && guard < 40) begin @(negedge clk); guard++; end
      while (clk_div_o[0] !== 1'b1 && guard < 80) begin @(negedge clk); guard++; end
      while (clk_div_o[0] === 1'b1 && hi < 40) begin hi++; @(negedge clk); end
      while (clk_div_o[0] === 1'b0 && lo < 40) begin lo++; @(negedge clk); end
   endtask

   task automatic expect_period(input int r, input string req);
      int hi, lo;
      measure(hi, lo);
      check({req, " high"}, hi, r / 2);
      check({req, " period"}, hi + lo, r);
   endtask

   task automatic reload(input int r);
      wr(4'h8, 32'(r) << 8);
      wr(4'h0, EN1 | REQ1 | TRIG);
      wr(4'h0, EN1);
   endtask

   task automatic t_reset;
      // R1 R10
      rd(4'h0, 32'h0, "R1");
      rd(4'h8, 32'h0000_0800, "R1");
      check("R1 output low", int'(clk_div_o[0]), 0);
   endtask

   task automatic t_regmap;
      // R2
      wr(4'h4, 32'hFFFF_FFFF);
      rd(4'h4, 32'h0, "R2");
      rd(4'h0, 32'h0, "R2");
      rd(4'h8, 32'h0000_0800, "R2");
      wr(4'h0, EN1);
      rd(4'h0, EN1, "R2 R3");
   endtask

   task automatic t_default;
      // R10 R6
      expect_period(8, "R10");
   endtask

   task automatic t_pending;
      int hi, lo, ok;
      // R4: written ratio stays pending
      wr(4'h8, 32'h0000_0500);
      rd(4'h8, 32'h0000_0500, "R4");
      expect_period(8, "R4 pending");
      wr(4'h0, EN1 | REQ1);
      expect_period(8, "R4 request only");
      wr(4'h0, EN1 | REQ1 | TRIG);
      // R8: every period during switch is whole old or whole new
      for (int i = 0; i < 3; i++) begin
         measure(hi, lo);
         ok = ((hi == 4 && hi + lo == 8) || (hi == 2 && hi + lo == 5)) ? 1 : 0;
         check("R8 whole period", ok, 1);
      end
      expect_period(5, "R4 applied");
      // R9
      wr(4'h0, EN1);
      expect_period(5, "R9");
      expect_period(5, "R9");
   endtask

   task automatic t_trig_only;
      // R5
      wr(4'h8, 32'h0000_0600);
      wr(4'h0, EN1 | TRIG);
      expect_period(5, "R5");
      wr(4'h0, EN1);
      expect_period(5, "R5");
   endtask

   task automatic t_illegal;
      // R7
      reload(7);
      expect_period(5, "R7 ratio 7");
      reload(3);
      expect_period(5, "R7 ratio 3");
   endtask

   task automatic t_ratios;
      // R6
      reload(4);
      expect_period(4, "R6 ratio 4");
      expect_period(4, "R6 ratio 4");
      reload(6);
      expect_period(6, "R6 ratio 6");
      reload(8);
      expect_period(8, "R6 ratio 8");
      reload(5);
      expect_period(5, "R6 ratio 5");
   endtask

   task automatic t_disable;
      int highs = 0;
      // R3
      wr(4'h0, 32'h0);
      @(negedge clk);
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (clk_div_o[0] !== 1'b0) highs++;
      end
      check("R3 disabled low", highs, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_regmap;
      t_default;
      t_pending;
      t_trig_only;
      t_illegal;
      t_ratios;
      t_disable;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #800_000;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule